// File: doc/BRIEF.md
# Packed complex fixed-point arithmetic unit

A purely combinational execution unit that sits beside a 32-bit processor ALU and gives it three complex-number operations. Each 32-bit operand holds one complex number. The real part sits in bits [31:16] and the imaginary part sits in bits [15:0]. Each part is a signed two's complement value with 4 integer bits and 12 fractional bits, so 1.0 is encoded as 0x1000.

A 2-bit select picks one of four behaviours:

- complex product of the two operands;
- complex sum of the two operands;
- squared magnitude of the first operand;
- an all-zero result.

The two overflow policies differ. The product and the sum wrap by truncation. The magnitude saturates each of its squares, then returns their 17-bit sum sign-extended to 32 bits. The result is valid in the same cycle as the inputs. The unit has no state.

Top module: `cplx_alu`

## Requirements
- R1: The real part of an operand or result is bits [31:16] and the imaginary part is bits [15:0], each signed with 12 fractional bits. A carry or borrow in one part never reaches the other part.
- R2: With `op_i` = 2'b00 the result is the complex product. Its real part is ac − bd and its imaginary part is ad + bc, where a/b are the real/imaginary parts of `opa_i` and c/d those of `opb_i`. Each real product is the full signed 32-bit product with the low 12 bits dropped, keeping bits [27:12].
- R3: In the complex product, each truncated product and each 16-bit add or subtract wraps modulo 2^16. For example, 0x8000 × 0x8000 contributes 0.
- R4: With `op_i` = 2'b01 the result holds the real parts summed and the imaginary parts summed, each wrapped to 16 bits with no saturation.
- R5: With `op_i` = 2'b10 each part of `opa_i` is squared. A square whose signed product has bits [31:27] not all equal clamps to 0x7FFF. Otherwise the square is bits [27:12] of the product.
- R6: The squared magnitude is the two saturated squares added at 17-bit width and sign-extended to 32 bits. The result is therefore at most 0x0000FFFE, and bits [31:17] are zero.
- R7: The squared-magnitude result does not depend on `opb_i`.
- R8: With `op_i` = 2'b11 the result is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation select: 00 product, 01 sum, 10 squared magnitude, 11 none |
| opa_i | input | 32 | First packed complex operand |
| opb_i | input | 32 | Second packed complex operand (ignored by the magnitude) |
| result_o | output | 32 | Packed complex result, or magnitude in the low 17 bits |

## Verification
The product is tried with identity and i×i operands, which tell a correct sign on the bd term apart from a swapped one. Operands built to overflow show whether truncation keeps bits [27:12] and whether the imaginary sum wraps. The sum is driven with values that carry out of the imaginary part and out of the maximum real value, so a carry that leaks between parts or saturates is exposed. The magnitude is tried one code each side of the 0x2D41/0x2D42 clamp boundary, with negative parts, and with 0x8000 in both parts. It is then repeated under different second operands. A long pseudo-random run of all four selects is compared against an integer model.

// File: rtl/cplx_pkg.sv
package cplx_pkg;
  localparam int PART_W = 16;
  localparam int FRAC_W = 12;
  localparam int WORD_W = 2 * PART_W;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_ADD  = 2'b01,
    OP_MAG  = 2'b10,
    OP_NONE = 2'b11
  } cplx_op_e;

  typedef struct packed {
    logic [PART_W-1:0] re;
    logic [PART_W-1:0] im;
  } cplx_t;
endpackage

// File: rtl/fxp_mul.sv
module fxp_mul #(
  parameter int W   = 16,
  parameter int F   = 12,
  parameter bit SAT = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int PW = 2 * W;
  localparam int HI = F + W - 1;

  logic signed [PW-1:0] prod;
  assign prod = $signed(a_i) * $signed(b_i);

  generate
    if (SAT) begin : g_sat
      logic [PW-1-HI:0] top;
      logic             fits;
      assign top  = prod[PW-1:HI];
      assign fits = (&top) | ~(|top);
      always_comb begin
        if (fits)             res_o = prod[HI:F];
        else if (prod[PW-1])  res_o = {1'b1, {(W-1){1'b0}}};
        else                  res_o = {1'b0, {(W-1){1'b1}}};
      end
    end else begin : g_trunc
      assign res_o = prod[HI:F];
    end
  endgenerate
endmodule

// File: rtl/cplx_mul_unit.sv
module cplx_mul_unit
  import cplx_pkg::*;
(
  input  cplx_t x_i,
  input  cplx_t y_i,
  output cplx_t z_o
);
  logic [PART_W-1:0] p_ac, p_bd, p_ad, p_bc;

  fxp_mul #(.W(PART_W), .F(FRAC_W), .SAT(1'b0)) i_ac (.a_i(x_i.re), .b_i(y_i.re), .res_o(p_ac));
  fxp_mul #(.W(PART_W), .F(FRAC_W), .SAT(1'b0)) i_bd (.a_i(x_i.im), .b_i(y_i.im), .res_o(p_bd));
  fxp_mul #(.W(PART_W), .F(FRAC_W), .SAT(1'b0)) i_ad (.a_i(x_i.re), .b_i(y_i.im), .res_o(p_ad));
  fxp_mul #(.W(PART_W), .F(FRAC_W), .SAT(1'b0)) i_bc (.a_i(x_i.im), .b_i(y_i.re), .res_o(p_bc));

  // 16-bit wrap on both terms
  assign z_o.re = p_ac - p_bd;
  assign z_o.im = p_ad + p_bc;
endmodule

// File: rtl/cplx_add_unit.sv
module cplx_add_unit
  import cplx_pkg::*;
(
  input  cplx_t x_i,
  input  cplx_t y_i,
  output cplx_t z_o
);
  // parts summed separately so no carry crosses bit 16
  assign z_o.re = x_i.re + y_i.re;
  assign z_o.im = x_i.im + y_i.im;
endmodule

// File: rtl/cplx_mag_unit.sv
module cplx_mag_unit
  import cplx_pkg::*;
(
  input  cplx_t             x_i,
  output logic [WORD_W-1:0] mag_o
);
  logic [PART_W-1:0] sq_re, sq_im;
  logic [PART_W:0]   sum;

  fxp_mul #(.W(PART_W), .F(FRAC_W), .SAT(1'b1)) i_sq_re (.a_i(x_i.re), .b_i(x_i.re), .res_o(sq_re));
  fxp_mul #(.W(PART_W), .F(FRAC_W), .SAT(1'b1)) i_sq_im (.a_i(x_i.im), .b_i(x_i.im), .res_o(sq_im));

  assign sum   = {sq_re[PART_W-1], sq_re} + {sq_im[PART_W-1], sq_im};
  assign mag_o = {{(WORD_W-PART_W-1){sum[PART_W]}}, sum};
endmodule

// File: rtl/cplx_alu.sv
module cplx_alu
  import cplx_pkg::*;
(
  input  logic [1:0]  op_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  output logic [31:0] result_o
);
  cplx_t             x, y, z_mul, z_add;
  logic [WORD_W-1:0] mag;

  assign x = opa_i;
  assign y = opb_i;

  cplx_mul_unit i_mul (.x_i(x), .y_i(y), .z_o(z_mul));
  cplx_add_unit i_add (.x_i(x), .y_i(y), .z_o(z_add));
  cplx_mag_unit i_mag (.x_i(x), .mag_o(mag));

  always_comb begin
    case (cplx_op_e'(op_i))
      OP_MUL:  result_o = z_mul;
      OP_ADD:  result_o = z_add;
      OP_MAG:  result_o = mag;
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/cplx_alu_chk.sv
module cplx_alu_chk (
  input logic [1:0]  op_i,
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic [31:0] result_o
);
  always_comb begin
    if (!$isunknown({op_i, opa_i, opb_i})) begin
      // R6: magnitude fits in 17 bits and is non-negative
      p_mag_bound_r6: assert (op_i != 2'b10 || result_o <= 32'h0000_FFFE);
      // R5: most negative real part always clamps its square
      p_mag_clamp_r5: assert (op_i != 2'b10 || opa_i[31:16] != 16'h8000
                              || result_o[15:0] >= 16'h7FFF);
      // R8: unused select gives zero
      p_none_zero_r8: assert (op_i != 2'b11 || result_o == 32'h0);
      // R4: adding zero returns the first operand
      p_add_ident_r4: assert (op_i != 2'b01 || opb_i != 32'h0 || result_o == opa_i);
      // R2: product with zero is zero
      p_mul_zero_r2:  assert (op_i != 2'b00 || opb_i != 32'h0 || result_o == 32'h0);
    end
  end
endmodule

bind cplx_alu cplx_alu_chk i_chk (
  .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o)
);

// File: tb/test_cplx_alu.sv
module test_cplx_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic [31:0] result;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cplx_alu i_cplx_alu (.op_i(op), .opa_i(opa), .opb_i(opb), .result_o(result));

  function automatic int part(logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int trunc_mul(int p, int q);
    return ((p * q) >>> 12) & 32'h0000_FFFF;
  endfunction

  function automatic int sat_sq(int p);
    int s = p * p;
    if (s > 32'h07FF_FFFF) return 32'h7FFF;
    return s >>> 12;
  endfunction

  function automatic logic [31:0] model(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    int ar = part(a[31:16]), ai = part(a[15:0]);
    int br = part(b[31:16]), bi = part(b[15:0]);
    int re, im;
    case (o)
      2'b00: begin
        re = (trunc_mul(ar, br) - trunc_mul(ai, bi)) & 32'hFFFF;
        im = (trunc_mul(ar, bi) + trunc_mul(ai, br)) & 32'hFFFF;
        return {re[15:0], im[15:0]};
      end
      2'b01: begin
        re = (ar + br) & 32'hFFFF;
        im = (ai + bi) & 32'hFFFF;
        return {re[15:0], im[15:0]};
      end
      2'b10: return 32'(sat_sq(ar) + sat_sq(ai));
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, opa, opb, result, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later (combinational path)
  task automatic apply(logic [1:0] o, logic [31:0] a, logic [31:0] b, string tag, logic [31:0] exp);
    @(negedge clk);
    op = o; opa = a; opb = b;
    #1;
    check(tag, exp);
    check({tag, "_model"}, model(o, a, b));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [31:0] a, b;
    op = 2'b11; opa = 32'h1234_5678; opb = 32'h9ABC_DEF0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R8 reset", 32'h0);

    apply(2'b00, 32'h1000_0000, 32'h1234_ABCD, "R2 identity", 32'h1234_ABCD);
    apply(2'b00, 32'h0000_1000, 32'h0000_1000, "R2 i_times_i", 32'hF000_0000);
    apply(2'b00, 32'h2000_1000, 32'h1800_E000, "R2 mixed", model(2'b00, 32'h2000_1000, 32'h1800_E000));
    apply(2'b00, 32'h8000_0000, 32'h8000_0000, "R3 min_sq_wrap", 32'h0);
    apply(2'b00, 32'h7000_7000, 32'h1000_1000, "R3 imag_wrap", 32'h0000_E000);
    apply(2'b01, 32'h7FFF_8000, 32'h0001_8000, "R4 wrap", 32'h8000_0000);
    apply(2'b01, 32'h7FFF_7FFF, 32'h0000_0000, "R4 max_plus_zero", 32'h7FFF_7FFF);
    apply(2'b01, 32'h0001_FFFF, 32'h0000_0001, "R1 no_carry_cross", 32'h0001_0000);
    apply(2'b01, 32'h0000_0000, 32'h0000_FFFF, "R1 no_borrow_cross", 32'h0000_FFFF);
    apply(2'b10, 32'h1000_1000, 32'h0, "R5 unit", 32'h0000_2000);
    apply(2'b10, 32'h2D41_0000, 32'h0, "R5 below_clamp", 32'h0000_7FFE);
    apply(2'b10, 32'h2D42_0000, 32'h0, "R5 at_clamp", 32'h0000_7FFF);
    apply(2'b10, 32'h0000_D2BE, 32'h0, "R5 neg_clamp", 32'h0000_7FFF);
    apply(2'b10, 32'h8000_0000, 32'h0, "R5 min_part", 32'h0000_7FFF);
    apply(2'b10, 32'h8000_8000, 32'h0, "R6 max_sum", 32'h0000_FFFE);
    apply(2'b10, 32'h7FFF_2D42, 32'h0, "R6 both_clamp", 32'h0000_FFFE);
    apply(2'b10, 32'h1800_F000, 32'hFFFF_FFFF, "R7 b_ones", 32'h0000_3400);
    apply(2'b10, 32'h1800_F000, 32'h8000_7FFF, "R7 b_mixed", 32'h0000_3400);
    apply(2'b10, 32'h1800_F000, 32'h0000_0000, "R7 b_zero", 32'h0000_3400);
    apply(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 ones", 32'h0);

    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr * 32'h9E37_79B9;
      @(negedge clk);
      op = 2'(k); opa = a; opb = b;
      #1;
      case (op)
        2'b00:   check("R2 random", model(op, a, b));
        2'b01:   check("R4 random", model(op, a, b));
        2'b10:   check("R5 random", model(op, a, b));
        default: check("R8 random", 32'h0);
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule